// File: doc/BRIEF.md
# Buffer Descriptor Ring Walker

This block steps through a circular list of 8-byte buffer descriptors that software places back to back in memory. It starts at a base address that software loads. It reads each descriptor as one 64-bit word. If hardware owns the descriptor, the block passes the buffer pointer and byte count to a data mover. It then waits for the mover to finish and writes the status halfword back with ownership cleared. After that it moves on to the next descriptor, or jumps back to the base if the descriptor carried the wrap flag.

The list has no link fields. Its end is marked only by the wrap flag in its last entry, and software and hardware pass entries back and forth through the ownership flag. A ring must hold at least four entries and at most 65536, so the index counter is 16 bits wide by default. When the walker meets an entry that software still owns, it parks on that address. It polls that entry again only after a kick strobe from software.

Top module: `desc_ring_walker`

## Requirements
- R1: While `rst_n` is low, and from the cycle after `enable` goes low, `rd_req`, `wr_en`, `buf_valid`, `done` and `halted` stay low and `desc_idx` reads 0.
- R2: When `enable` rises, the first read goes to the base address latched at that time, and `desc_idx` is 0.
- R3: A descriptor word is laid out big-endian: `rd_data[63:48]` is the status, `[47:32]` is the byte count and `[31:0]` is the buffer pointer. Status bit 15 = 1 means hardware owns it. For an owned entry, `buf_addr` and `buf_len` carry the pointer and the count.
- R4: After writing back an entry whose status bit 13 is 0, the next read address is the previous one plus 8, and `desc_idx` increases by 1.
- R5: After writing back an entry whose status bit 13 is 1, the next read goes to the ring base, and `desc_idx` returns to 0.
- R6: An entry with bit 15 = 0 produces no handoff and raises `halted`. `rd_addr` stays on that entry, and no new read is issued until `kick` is pulsed. A kick re-reads the same address and never skips ahead.
- R7: When `buf_done` arrives, exactly one write is issued to the entry's address, together with a one-cycle `done`. The written halfword has bit 15 cleared, bits 14:8 copied from the fetched status (so the wrap flag is kept), and bits 7:0 taken from `buf_result`.
- R8: A base with nonzero bits 2:0 is rounded down to an 8-byte boundary, and `align_err` is held high until `enable` drops. All read addresses are 8-byte aligned.
- R9: `buf_valid` and `buf_addr` hold steady until `buf_ready`. No read or write is issued while a buffer is being offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the walker; low returns it to idle |
| base_addr | input | AW | Ring base address, latched on enable |
| kick | input | 1 | Software strobe to re-poll a parked entry |
| rd_req | output | 1 | Descriptor read request, held until rd_valid |
| rd_addr | output | AW | Descriptor read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 64 | Descriptor word |
| wr_en | output | 1 | Status writeback strobe |
| wr_addr | output | AW | Writeback address |
| wr_data | output | 16 | Writeback status halfword |
| buf_valid | output | 1 | Buffer offered to the data mover |
| buf_addr | output | 32 | Buffer pointer |
| buf_len | output | 16 | Buffer byte count |
| buf_ready | input | 1 | Data mover accepts the buffer |
| buf_done | input | 1 | Data mover finished the buffer |
| buf_result | input | RESW | Result bits for the status writeback |
| done | output | 1 | One-cycle pulse per completed entry |
| halted | output | 1 | Parked on an entry that hardware does not own |
| align_err | output | 1 | Base address was misaligned |
| desc_idx | output | IDXW | Index of the current entry |

## Verification
If the index or base register goes wrong, `rd_addr` shows it on the very next read request, one cycle after the writeback of the previous entry. If the ownership decode goes wrong, a buffer is offered when none should be, or the walker parks early. That shows up as a handoff count or a park address that differs from the bench's count right after the ring settles. A wrong writeback mask shows in `wr_data` in the same cycle as `done`. Later, the altered status bits in memory also show up as a missed wrap or a missed park.

// File: rtl/desc_ring_walker.sv
module desc_ring_walker #(
  parameter int AW       = 32,
  parameter int IDXW     = 16,
  parameter int OWN_BIT  = 15,
  parameter int WRAP_BIT = 13,
  parameter int RESW     = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [AW-1:0]   base_addr,
  input  logic            kick,
  output logic            rd_req,
  output logic [AW-1:0]   rd_addr,
  input  logic            rd_valid,
  input  logic [63:0]     rd_data,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [15:0]     wr_data,
  output logic            buf_valid,
  output logic [31:0]     buf_addr,
  output logic [15:0]     buf_len,
  input  logic            buf_ready,
  input  logic            buf_done,
  input  logic [RESW-1:0] buf_result,
  output logic            done,
  output logic            halted,
  output logic            align_err,
  output logic [IDXW-1:0] desc_idx
);

  localparam logic [15:0] KEEP_MASK = ~((16'h1 << OWN_BIT) | ((16'h1 << RESW) - 16'h1));

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_HAND, S_BUSY, S_WB, S_HALT} walk_t;

  walk_t          st;
  logic [AW-1:0]  base_q;
  logic [IDXW-1:0] idx;
  logic [15:0]    stat_q;
  logic [15:0]    len_q;
  logic [31:0]    ptr_q;
  logic           err_q;
  logic [AW-1:0]  cur_addr;

  assign cur_addr  = base_q + (AW'(idx) << 3);
  assign rd_req    = (st == S_FETCH);
  assign rd_addr   = cur_addr;
  assign wr_en     = (st == S_WB);
  assign wr_addr   = cur_addr;
  assign wr_data   = (stat_q & KEEP_MASK) | 16'(buf_result_q);
  assign buf_valid = (st == S_HAND);
  assign buf_addr  = ptr_q;
  assign buf_len   = len_q;
  assign done      = (st == S_WB);
  assign halted    = (st == S_HALT);
  assign align_err = err_q;
  assign desc_idx  = idx;

  logic [RESW-1:0] buf_result_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      base_q       <= '0;
      idx          <= '0;
      stat_q       <= '0;
      len_q        <= '0;
      ptr_q        <= '0;
      err_q        <= 1'b0;
      buf_result_q <= '0;
    end else if (!enable) begin
      st    <= S_IDLE;
      idx   <= '0;
      err_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          base_q <= {base_addr[AW-1:3], 3'b000};
          err_q  <= |base_addr[2:0];
          idx    <= '0;
          st     <= S_FETCH;
        end
        S_FETCH: if (rd_valid) begin
          stat_q <= rd_data[63:48];
          len_q  <= rd_data[47:32];
          ptr_q  <= rd_data[31:0];
          st     <= rd_data[48+OWN_BIT] ? S_HAND : S_HALT;
        end
        S_HAND: if (buf_ready) st <= S_BUSY;
        S_BUSY: if (buf_done) begin
          buf_result_q <= buf_result;
          st           <= S_WB;
        end
        S_WB: begin
          idx <= stat_q[WRAP_BIT] ? '0 : idx + 1'b1;
          st  <= S_FETCH;
        end
        S_HALT: if (kick) st <= S_FETCH;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ring_walker_chk.sv
module ring_walker_chk #(
  parameter int AW      = 32,
  parameter int OWN_BIT = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          kick,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_valid,
  input logic          wr_en,
  input logic [15:0]   wr_data,
  input logic          buf_valid,
  input logic [31:0]   buf_addr,
  input logic          buf_ready,
  input logic          done,
  input logic          halted
);

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!rd_req && !wr_en && !buf_valid && !done && !halted));

  p_fetch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid && enable) |=> (rd_req && $stable(rd_addr)));

  p_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !kick && enable) |=> (halted && !rd_req));

  p_owner_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !wr_data[OWN_BIT]);

  p_single_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  p_next_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && enable) |=> rd_req);

  p_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr[2:0] == 3'b000));

  p_offer_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && !buf_ready && enable) |=> (buf_valid && $stable(buf_addr)));

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> (!rd_req && !wr_en));

endmodule

bind desc_ring_walker ring_walker_chk #(.AW(AW), .OWN_BIT(OWN_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .kick(kick),
  .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
  .wr_en(wr_en), .wr_data(wr_data), .buf_valid(buf_valid),
  .buf_addr(buf_addr), .buf_ready(buf_ready), .done(done), .halted(halted)
);

// File: tb/sim_desc_ring_walker.sv
module sim_desc_ring_walker;
  logic        clk = 1'b0;
  logic        rst_n, enable, kick;
  logic [31:0] base_addr;
  logic        rd_req, rd_valid;
  logic [31:0] rd_addr;
  logic [63:0] rd_data;
  logic        wr_en;
  logic [31:0] wr_addr;
  logic [15:0] wr_data;
  logic        buf_valid, buf_ready, buf_done;
  logic [31:0] buf_addr;
  logic [15:0] buf_len;
  logic [7:0]  buf_result;
  logic        done, halted, align_err;
  logic [15:0] desc_idx;

  logic        sw_we;
  logic [4:0]  sw_a;
  logic [15:0] sw_val;
  logic [15:0] m_st [0:31];
  logic [2:0]  mv_cnt;
  logic [1:0]  rdy_cnt;

  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] sh [0:31];
  logic [31:0] exp_base;
  int exp_idx, hand, ring_n;
  bit first_fetch, rd_prev;

  always #10 clk = ~clk;

  desc_ring_walker u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .base_addr(base_addr), .kick(kick),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .buf_valid(buf_valid), .buf_addr(buf_addr), .buf_len(buf_len),
    .buf_ready(buf_ready), .buf_done(buf_done), .buf_result(buf_result),
    .done(done), .halted(halted), .align_err(align_err), .desc_idx(desc_idx)
  );

  function automatic logic [15:0] f_len(input int a);
    return 16'(16'h0100 + a * 7);
  endfunction

  function automatic logic [31:0] f_ptr(input int a);
    return 32'h8000_0000 + (32'(a) << 8);
  endfunction

  function automatic logic [15:0] mk(input int i, input bit own, input bit wrap);
    return {own, 1'b0, wrap, 2'b00, 3'(i), 8'h3C};
  endfunction

  assign buf_ready = (rdy_cnt != 2'd0);

  always @(posedge clk) begin
    rdy_cnt  <= rdy_cnt + 2'd1;
    rd_valid <= 1'b0;
    if (rd_req && !rd_valid) begin
      rd_valid <= 1'b1;
      rd_data  <= {m_st[rd_addr[7:3]], f_len(int'(rd_addr[7:3])), f_ptr(int'(rd_addr[7:3]))};
    end
    if (wr_en) m_st[wr_addr[7:3]] <= wr_data;
    if (sw_we) m_st[sw_a] <= sw_val;
    buf_done <= 1'b0;
    if (mv_cnt != 3'd0) begin
      mv_cnt <= mv_cnt - 3'd1;
      if (mv_cnt == 3'd1) buf_done <= 1'b1;
    end else if (buf_valid && buf_ready) begin
      mv_cnt     <= 3'd3;
      buf_result <= buf_len[7:0] ^ 8'hA5;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    int a;
    @(negedge clk);
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (rd_req && !rd_prev) begin
      logic [31:0] ea = exp_base + 32'(exp_idx * 8);
      chk(rd_addr == ea, first_fetch ? "R2" : (exp_idx == 0 ? "R5" : "R4"), rd_addr, ea);
      first_fetch = 0;
    end
    rd_prev = rd_req;
    if (buf_valid && buf_ready) begin
      a = int'(exp_base[7:3]) + exp_idx;
      chk(buf_addr == f_ptr(a), "R3", buf_addr, f_ptr(a));
      chk(buf_len == f_len(a), "R3", 32'(buf_len), 32'(f_len(a)));
      chk(desc_idx == 16'(exp_idx), "R4", 32'(desc_idx), 32'(exp_idx));
      hand++;
    end
    if (wr_en) begin
      logic [15:0] ew;
      logic [31:0] ea;
      a  = int'(exp_base[7:3]) + exp_idx;
      ew = {1'b0, sh[a][14:8], f_len(a)[7:0] ^ 8'hA5};
      ea = exp_base + 32'(exp_idx * 8);
      chk(wr_addr == ea, "R7", wr_addr, ea);
      chk(wr_data == ew, "R7", 32'(wr_data), 32'(ew));
      chk(done == 1'b1, "R7", 32'(done), 32'd1);
      exp_idx = sh[a][13] ? 0 : exp_idx + 1;
    end
  endtask

  task automatic sw_set(input int a, input logic [15:0] v);
    sw_we = 1'b1; sw_a = 5'(a); sw_val = v; sh[a] = v;
    tick();
    sw_we = 1'b0;
  endtask

  task automatic pulse_kick();
    kick = 1'b1;
    tick();
    kick = 1'b0;
  endtask

  task automatic wait_halt();
    int n = 0;
    while (!halted && n < 3000) begin tick(); n++; end
    chk(halted == 1'b1, "R6", 32'(halted), 32'd1);
  endtask

  task automatic run_ring(input logic [31:0] base, input int n, input int k);
    int b0, h, e;
    logic [31:0] park;
    enable = 1'b0;
    tick(); tick();
    chk(!rd_req && !buf_valid && !wr_en && !halted, "R1", {rd_req, buf_valid, wr_en, halted}, 0);
    chk(desc_idx == 0, "R1", 32'(desc_idx), 0);
    b0 = int'(base[7:3]);
    ring_n = n;
    for (int i = 0; i < n; i++) sw_set(b0 + i, mk(i, i < k, i == n - 1));
    exp_base = {base[31:3], 3'b000};
    exp_idx = 0; first_fetch = 1; hand = 0;
    base_addr = base;
    enable = 1'b1;
    tick();
    wait_halt();
    h = k % n;
    park = exp_base + 32'(h * 8);
    chk(hand == k, "R6", 32'(hand), 32'(k));
    chk(rd_addr == park, "R6", rd_addr, park);
    chk(desc_idx == 16'(h), "R5", 32'(desc_idx), 32'(h));
    chk(align_err == (base[2:0] != 3'b000), "R8", 32'(align_err), 32'(base[2:0] != 0));
    repeat (8) tick();
    chk(halted && hand == k && rd_addr == park, "R6", rd_addr, park);
    pulse_kick();
    wait_halt();
    chk(hand == k && rd_addr == park, "R6", rd_addr, park);
    for (int j = 0; j < 2; j++) begin
      e = (h + j) % n;
      sw_set(b0 + e, mk(e, 1'b1, e == n - 1));
    end
    pulse_kick();
    wait_halt();
    park = exp_base + 32'(((h + 2) % n) * 8);
    chk(hand == k + 2, "R6", 32'(hand), 32'(k + 2));
    chk(rd_addr == park, (h + 2) >= n ? "R5" : "R4", rd_addr, park);
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b0; kick = 1'b0; base_addr = '0;
    sw_we = 1'b0; sw_a = '0; sw_val = '0;
    mv_cnt = '0; rdy_cnt = '0; buf_result = '0; rd_data = '0;
    exp_base = '0; exp_idx = 0; hand = 0; ring_n = 4; first_fetch = 1; rd_prev = 0;
    for (int i = 0; i < 32; i++) begin m_st[i] = '0; sh[i] = '0; end
    repeat (3) tick();
    chk(!rd_req && !wr_en && !buf_valid && !done && !halted && !align_err, "R1",
        {rd_req, wr_en, buf_valid, done, halted, align_err}, 0);
    chk(desc_idx == 0, "R1", 32'(desc_idx), 0);
    rst_n = 1'b1;
    tick();
    for (int n = 4; n <= 6; n++)
      for (int k = 0; k <= n; k++)
        run_ring(32'h40, n, k);
    run_ring(32'h45, 4, 4);
    run_ring(32'h83, 5, 2);
    run_ring(32'h80, 4, 1);
    enable = 1'b0;
    tick(); tick();
    chk(!align_err && !rd_req, "R8", {align_err, rd_req}, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule